// File: doc/BRIEF.md
# System Clock Source Switch Controller

This block decides which of four oscillators drives the system clock: a fast internal oscillator, a slow internal oscillator, an external crystal oscillator and a frequency multiplier. Software reaches it through a small byte-wide register bus. It asks for a new master clock by writing a target code with a start bit. The controller then holds a busy flag until the chosen oscillator reports ready. At that point it moves the master code over and raises a switch-done flag. A pending switch can be abandoned by clearing busy, which copies the current master back into the target.

The block also drives the oscillator enables. Software sets a wish for each one, and hardware then overrides it. An oscillator stays on while it is the master, while it is the target of a pending switch, or while it is the reference of a running multiplier. The multiplier also stays on while the clock output pin is busy with it. A clock-failure monitor can be armed by software and cannot be disarmed except by reset. Once it has seen a failure, it forces the multiplier off and drops the master from the external oscillator back to the fast internal one. An interrupt line reports switch completion and clock failure, each behind its own enable.

Top module: `clksw_top`

## Requirements
- R1: After reset the master and target codes are 3'b001 (fast internal), busy and done are 0, and the effective enables read 4'b0001 (bit 0 fast internal, bit 1 slow internal, bit 2 external, bit 3 multiplier).
- R2: Source codes are 3'b001 fast internal, 3'b010 slow internal, 3'b100 external and 3'b111 multiplier. A requested target with any other code is taken as 3'b001.
- R3: A write to address 1 with bit 3 (start) set, while idle, sets busy (read bit 4) and loads the target (bits 2:0), provided the new target differs from the master. The master code stays unchanged until the target's ready input is high at a clock edge. That edge moves the target into the master, clears busy and sets done (read bit 5).
- R4: An oscillator's effective enable is 1 whenever it is the master or the target of a pending switch, even when its software bit (address 0, bits 3:0) is 0.
- R5: The multiplier enable is 1 while the clock-output-busy input is high.
- R6: While the multiplier is enabled, its reference is also enabled. Address 3 bit 0 selects the reference: 0 for fast internal, 1 for external.
- R7: Once the failure flag (address 4 bit 1) is set, the multiplier enable is 0 regardless of every force-on cause, and the flag stays set until reset.
- R8: While busy, a write to address 1 with bit 4 at 0 aborts the switch: the target returns to the master and busy clears. This holds even when the start bit is set in the same write.
- R9: The monitor enable (address 4 bit 0) is set by writing 1 and ignores writes of 0. While it is 0, the failure input has no effect.
- R10: A detected failure while the external oscillator is master changes the master and the target to fast internal within one clock and cancels any pending switch.
- R11: irq equals (done and address 1 bit 6) or (failure flag and address 4 bit 2). Writing 1 to address 1 bit 5 clears done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational) |
| osc_rdy | input | 4 | Ready from each oscillator, indexed like the enables |
| clkout_pll_busy | input | 1 | Clock output pin is busy and has the multiplier selected |
| fail_det | input | 1 | Clock-failure detector |
| osc_en | output | 4 | Effective oscillator enables |
| master_code | output | 3 | Current master source code |
| irq | output | 1 | Interrupt |

## Verification
The hardest case to reach is a failure that arrives while a switch is in flight and the external oscillator is still master. The monitor must be armed, and the master must have already moved to the external oscillator. A second switch must then be started toward the multiplier, whose ready input is held low so that the switch stays pending. The bench builds this state one step at a time. It pulses the failure input for one cycle and then checks that the fallback happened, that busy cleared, and that the multiplier stays off even when software and the clock output both ask for it.

// File: rtl/clksw_pkg.sv
package clksw_pkg;
    localparam int NUM_SRC  = 4;
    localparam int CODE_W   = 3;
    localparam int ADDR_W   = 3;
    localparam int DATA_W   = 8;
    localparam int IDX_FAST = 0;
    localparam int IDX_SLOW = 1;
    localparam int IDX_EXT  = 2;
    localparam int IDX_MULT = 3;

    localparam logic [ADDR_W-1:0] A_OSC  = 3'd0;
    localparam logic [ADDR_W-1:0] A_SW   = 3'd1;
    localparam logic [ADDR_W-1:0] A_MST  = 3'd2;
    localparam logic [ADDR_W-1:0] A_MULT = 3'd3;
    localparam logic [ADDR_W-1:0] A_MON  = 3'd4;

    typedef enum logic [CODE_W-1:0] {
        SRC_FAST_INT = 3'b001,
        SRC_SLOW_INT = 3'b010,
        SRC_EXT      = 3'b100,
        SRC_MULT     = 3'b111
    } src_code_e;

    typedef struct packed {
        logic              irq_en;
        logic              done_clr;
        logic              keep_busy;
        logic              go;
        logic [CODE_W-1:0] target_raw;
    } swctl_wr_t;

    function automatic src_code_e sanitize(input logic [CODE_W-1:0] raw);
        case (raw)
            3'b010:  return SRC_SLOW_INT;
            3'b100:  return SRC_EXT;
            3'b111:  return SRC_MULT;
            default: return SRC_FAST_INT;
        endcase
    endfunction

    function automatic logic [1:0] src_index(input src_code_e c);
        case (c)
            SRC_SLOW_INT: return 2'(IDX_SLOW);
            SRC_EXT:      return 2'(IDX_EXT);
            SRC_MULT:     return 2'(IDX_MULT);
            default:      return 2'(IDX_FAST);
        endcase
    endfunction
endpackage

// File: rtl/clksw_safety.sv
module clksw_safety
    import clksw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic mon_wr,
    input  logic mon_set,
    input  logic ie_val,
    input  logic fail_det,
    output logic mon_en,
    output logic fail_flag,
    output logic fail_ie,
    output logic fail_hit
);
    assign fail_hit = mon_en & fail_det;

    always_ff @(posedge clk) begin
        if (rst) begin
            mon_en    <= 1'b0;
            fail_flag <= 1'b0;
            fail_ie   <= 1'b0;
        end else begin
            if (mon_wr) begin
                fail_ie <= ie_val;
                if (mon_set) mon_en <= 1'b1;
            end
            if (fail_hit) fail_flag <= 1'b1;
        end
    end

    assert_monitor_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        mon_en |=> mon_en);
    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        fail_flag |=> fail_flag);
    assert_no_flag_unarmed_R9: assert property (@(posedge clk) disable iff (rst)
        (!mon_en && !fail_flag) |=> !fail_flag);
endmodule

// File: rtl/clksw_seq.sv
module clksw_seq
    import clksw_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               ctl_wr,
    input  swctl_wr_t          ctl,
    input  logic [NUM_SRC-1:0] osc_rdy,
    input  logic               fail_hit,
    output src_code_e          master,
    output src_code_e          target,
    output logic               busy,
    output logic               done,
    output logic               irq_en
);
    src_code_e req_tgt;
    logic      abort_req, start_req, fall_back, tgt_ready;

    assign req_tgt   = sanitize(ctl.target_raw);
    assign abort_req = ctl_wr & busy & ~ctl.keep_busy;
    assign start_req = ctl_wr & ~busy & ctl.go & (req_tgt != master);
    assign fall_back = fail_hit & (master == SRC_EXT);
    assign tgt_ready = osc_rdy[src_index(target)];

    always_ff @(posedge clk) begin
        if (rst) begin
            master <= SRC_FAST_INT;
            target <= SRC_FAST_INT;
            busy   <= 1'b0;
            done   <= 1'b0;
            irq_en <= 1'b0;
        end else begin
            if (ctl_wr) irq_en <= ctl.irq_en;
            if (ctl_wr && ctl.done_clr) done <= 1'b0;
            if (fall_back) begin
                master <= SRC_FAST_INT;
                target <= SRC_FAST_INT;
                busy   <= 1'b0;
            end else if (abort_req) begin
                target <= master;
                busy   <= 1'b0;
            end else if (busy && tgt_ready) begin
                master <= target;
                busy   <= 1'b0;
                done   <= 1'b1;
            end else if (start_req) begin
                target <= req_tgt;
                busy   <= 1'b1;
            end
        end
    end

    assert_switch_done_R3: assert property (@(posedge clk) disable iff (rst)
        (busy && tgt_ready && !abort_req && !fall_back) |=> (master == $past(target)) && done && !busy);
    assert_idle_match_R3: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (target == master));
    assert_abort_restore_R8: assert property (@(posedge clk) disable iff (rst)
        (abort_req && !fall_back) |=> (target == $past(master)) && !busy);
    assert_fallback_R10: assert property (@(posedge clk) disable iff (rst)
        fall_back |=> (master == SRC_FAST_INT) && !busy);
    assert_code_valid_R2: assert property (@(posedge clk) disable iff (rst)
        master inside {SRC_FAST_INT, SRC_SLOW_INT, SRC_EXT, SRC_MULT});
endmodule

// File: rtl/clksw_force.sv
module clksw_force
    import clksw_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  src_code_e          master,
    input  src_code_e          target,
    input  logic               busy,
    input  logic [NUM_SRC-1:0] sw_en,
    input  logic               ref_ext,
    input  logic               clkout_pll_busy,
    input  logic               fail_flag,
    output logic [NUM_SRC-1:0] osc_en
);
    logic [NUM_SRC-1:0] hold;
    logic               mult_on;

    assign mult_on = (sw_en[IDX_MULT] | hold[IDX_MULT] | clkout_pll_busy) & ~fail_flag;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assign hold[i] = (src_index(master) == 2'(i)) | (busy & (src_index(target) == 2'(i)));
        if (i == IDX_MULT) begin : g_mult
            assign osc_en[i] = mult_on;
        end else if (i == IDX_EXT) begin : g_ext
            assign osc_en[i] = sw_en[i] | hold[i] | (mult_on & ref_ext);
        end else if (i == IDX_FAST) begin : g_fast
            assign osc_en[i] = sw_en[i] | hold[i] | (mult_on & ~ref_ext);
        end else begin : g_plain
            assign osc_en[i] = sw_en[i] | hold[i];
        end
    end

    assert_fail_kills_mult_R7: assert property (@(posedge clk) disable iff (rst)
        fail_flag |-> !osc_en[IDX_MULT]);
    assert_master_on_R4: assert property (@(posedge clk) disable iff (rst)
        !(fail_flag && master == SRC_MULT) |-> osc_en[src_index(master)]);
    assert_target_on_R4: assert property (@(posedge clk) disable iff (rst)
        (busy && !(fail_flag && target == SRC_MULT)) |-> osc_en[src_index(target)]);
    assert_ref_follow_R6: assert property (@(posedge clk) disable iff (rst)
        osc_en[IDX_MULT] |-> osc_en[ref_ext ? IDX_EXT : IDX_FAST]);
endmodule

// File: rtl/clksw_top.sv
module clksw_top
    import clksw_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_wr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic [NUM_SRC-1:0] osc_rdy,
    input  logic               clkout_pll_busy,
    input  logic               fail_det,
    output logic [NUM_SRC-1:0] osc_en,
    output logic [CODE_W-1:0]  master_code,
    output logic               irq
);
    logic [NUM_SRC-1:0] sw_en;
    logic               ref_ext;
    src_code_e          master, target;
    logic               busy, done, sw_ie;
    logic               mon_en, fail_flag, fail_ie, fail_hit;
    swctl_wr_t          ctl;

    assign ctl = swctl_wr_t'(reg_wdata[$bits(swctl_wr_t)-1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            sw_en   <= NUM_SRC'(1) << IDX_FAST;
            ref_ext <= 1'b0;
        end else if (reg_wr) begin
            if (reg_addr == A_OSC)  sw_en   <= reg_wdata[NUM_SRC-1:0];
            if (reg_addr == A_MULT) ref_ext <= reg_wdata[0];
        end
    end

    clksw_seq u_seq (
        .clk(clk), .rst(rst),
        .ctl_wr(reg_wr && reg_addr == A_SW), .ctl(ctl),
        .osc_rdy(osc_rdy), .fail_hit(fail_hit),
        .master(master), .target(target),
        .busy(busy), .done(done), .irq_en(sw_ie)
    );

    clksw_safety u_safe (
        .clk(clk), .rst(rst),
        .mon_wr(reg_wr && reg_addr == A_MON),
        .mon_set(reg_wdata[0]), .ie_val(reg_wdata[2]),
        .fail_det(fail_det),
        .mon_en(mon_en), .fail_flag(fail_flag),
        .fail_ie(fail_ie), .fail_hit(fail_hit)
    );

    clksw_force u_force (
        .clk(clk), .rst(rst),
        .master(master), .target(target), .busy(busy),
        .sw_en(sw_en), .ref_ext(ref_ext),
        .clkout_pll_busy(clkout_pll_busy), .fail_flag(fail_flag),
        .osc_en(osc_en)
    );

    assign master_code = master;
    assign irq = (done & sw_ie) | (fail_flag & fail_ie);

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_OSC:  reg_rdata[NUM_SRC-1:0] = osc_en;
            A_SW:   reg_rdata = {1'b0, sw_ie, done, busy, 1'b0, target};
            A_MST:  reg_rdata[CODE_W-1:0] = master;
            A_MULT: reg_rdata[0] = ref_ext;
            A_MON:  reg_rdata[2:0] = {fail_ie, fail_flag, mon_en};
            default: reg_rdata = '0;
        endcase
    end

    assert_irq_needs_cause_R11: assert property (@(posedge clk) disable iff (rst)
        irq |-> (done || fail_flag));
endmodule

// File: tb/sim_clksw_top.sv
module sim_clksw_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [3:0] osc_rdy = '0;
    logic       clkout_pll_busy = 1'b0;
    logic       fail_det = 1'b0;
    logic [3:0] osc_en;
    logic [2:0] master_code;
    logic       irq;
    int         n_chk = 0;
    int         n_bad = 0;

    always #4 clk = ~clk;

    clksw_top u0 (.*);

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd(3'd1, v); chk("R1 switch reg", v, 8'h01);
        chk("R1 master", 8'(master_code), 8'h01);
        chk("R1 enables", 8'(osc_en), 8'h01);
        chk("R1 irq", 8'(irq), 8'h00);
    endtask

    task automatic t_switch_slow;
        logic [7:0] v;
        wr(3'd1, 8'h0A);
        rd(3'd1, v); chk("R3 busy set", v, 8'h12);
        chk("R3 master held", 8'(master_code), 8'h01);
        chk("R4 target forced", 8'(osc_en), 8'h03);
        osc_rdy[1] = 1'b1;
        @(negedge clk);
        chk("R3 master moved", 8'(master_code), 8'h02);
        rd(3'd1, v); chk("R3 done", v, 8'h22);
        chk("R11 irq masked", 8'(irq), 8'h00);
        wr(3'd1, 8'h40);
        chk("R11 irq on", 8'(irq), 8'h01);
        wr(3'd1, 8'h60);
        rd(3'd1, v); chk("R11 done cleared", v, 8'h42);
        chk("R11 irq off", 8'(irq), 8'h00);
    endtask

    task automatic t_invalid_code;
        logic [7:0] v;
        wr(3'd1, 8'h0E);
        rd(3'd1, v); chk("R2 invalid target", v, 8'h11);
        osc_rdy[0] = 1'b1;
        @(negedge clk);
        chk("R2 back to fast", 8'(master_code), 8'h01);
        wr(3'd1, 8'h20);
        rd(3'd1, v); chk("R2 idle", v, 8'h01);
    endtask

    task automatic t_abort;
        logic [7:0] v;
        wr(3'd1, 8'h0C);
        rd(3'd1, v); chk("R8 pending", v, 8'h14);
        chk("R4 ext forced", 8'(osc_en), 8'h05);
        wr(3'd1, 8'h0C);
        rd(3'd1, v); chk("R8 aborted", v, 8'h01);
        chk("R8 ext released", 8'(osc_en), 8'h01);
    endtask

    task automatic t_sw_enable;
        wr(3'd0, 8'h04);
        chk("R4 sw enable", 8'(osc_en), 8'h05);
        wr(3'd0, 8'h00);
        chk("R4 master kept on", 8'(osc_en), 8'h01);
    endtask

    task automatic t_mult;
        wr(3'd0, 8'h08);
        chk("R6 ref fast", 8'(osc_en), 8'h09);
        wr(3'd3, 8'h01);
        chk("R6 ref ext", 8'(osc_en), 8'h0D);
        wr(3'd0, 8'h00);
        chk("R6 mult off", 8'(osc_en), 8'h01);
        clkout_pll_busy = 1'b1;
        #1;
        chk("R5 clkout forces", 8'(osc_en), 8'h0D);
        wr(3'd3, 8'h00);
        chk("R5 ref moves", 8'(osc_en), 8'h09);
        clkout_pll_busy = 1'b0;
        #1;
        chk("R5 release", 8'(osc_en), 8'h01);
    endtask

    task automatic t_failure;
        logic [7:0] v;
        osc_rdy[2] = 1'b1;
        wr(3'd1, 8'h0C);
        @(negedge clk);
        chk("R3 on ext", 8'(master_code), 8'h04);
        wr(3'd1, 8'h20);
        fail_det = 1'b1;
        @(negedge clk); @(negedge clk);
        fail_det = 1'b0;
        chk("R9 unarmed ignored", 8'(master_code), 8'h04);
        rd(3'd4, v); chk("R9 no flag", v, 8'h00);
        wr(3'd4, 8'h05);
        rd(3'd4, v); chk("R9 armed", v, 8'h05);
        osc_rdy[3] = 1'b0;
        wr(3'd1, 8'h0F);
        rd(3'd1, v); chk("R10 pending mult", v, 8'h17);
        chk("R6 mult with ref", 8'(osc_en), 8'h0D);
        @(negedge clk);
        fail_det = 1'b1;
        @(negedge clk);
        fail_det = 1'b0;
        chk("R10 fallback", 8'(master_code), 8'h01);
        rd(3'd1, v); chk("R10 cancelled", v, 8'h01);
        rd(3'd4, v); chk("R7 flag", v, 8'h07);
        chk("R7 enables", 8'(osc_en), 8'h01);
        chk("R11 fail irq", 8'(irq), 8'h01);
        wr(3'd0, 8'h08);
        clkout_pll_busy = 1'b1;
        #1;
        chk("R7 mult blocked", 8'(osc_en), 8'h01);
        wr(3'd4, 8'h00);
        rd(3'd4, v); chk("R9 sticky", v, 8'h03);
        chk("R11 fail irq masked", 8'(irq), 8'h00);
    endtask

    initial begin
        #100000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_switch_slow();
        t_invalid_code();
        t_abort();
        t_sw_enable();
        t_mult();
        t_failure();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule